// File: doc/BRIEF.md
# Configuration Readback Serializer

This block sends the stored configuration image, together with captured logic state, out of the device one bit per configuration clock on a single serial pin. An active-low request input starts a transfer and holds it running. The block walks an external bit store through a read address and places each returned bit on the output without inverting it. Each frame of data bits has a low start bit before it and a high stop bit after it. The block sends no preamble and no length count. The first start bit comes out a fixed number of clocks after the request is accepted. After the last frame the output holds high until the request is released.

A permission setting allows unlimited readbacks, exactly one readback since reset, or none. A capture-mode setting controls when the block raises the write strobe of the capture memory. The strobe can pulse once when a readback is entered, follow a level-sensitive internal control signal, do both, or never fire. Until configuration is complete, readback is disabled and the request pin only drives the global 3-state output.

Top module: `cfg_readback_ser`

## Requirements
- R1: A readback is accepted at a rising edge of `clk` where `req_n` is sampled low, `req_n` was sampled high at each of the two preceding edges, `cfg_done` is 1 and the permission allows it. A transfer always begins at frame 0.
- R2: After the accepting edge, `sdo` stays high for `LATENCY` cycles. The first start bit is driven in the cycle that follows the `LATENCY`-th edge after the accepting edge.
- R3: Each frame is a 0 start bit, then `FRAME_BITS` data bits, then a 1 stop bit. Frames 0 to `FRAMES-1` follow back to back. The data bit for frame f, bit b (b ascending) is `rd_bit` returned for `rd_addr = f*FRAME_BITS + b`, sent uninverted. After the last stop bit, `sdo` stays 1 while `req_n` stays low.
- R4: `req_n` sampled high during a transfer ends it, and `sdo` is 1 from the next cycle. A new transfer needs `req_n` high for at least two edges. A single high edge followed by low starts nothing.
- R5: `perm` encoding: 2'b00 prohibits readback, so requests are ignored and `sdo` stays 1. 2'b01 allows one readback. 2'b10 and 2'b11 allow any number.
- R6: A one-bit used flag is cleared by reset and set by every accepted readback. With `perm`=2'b01 and the flag set, requests are ignored and `sdo` stays 1.
- R7: `cap_mode` bit 0 enables a one-cycle `cap_we` pulse in the cycle after the accepting edge. `cap_mode` bit 1 makes `cap_we` high whenever `cap_ctl_n` is 0 and `cfg_done` is 1. Mode 3 ORs the two sources, and mode 0 never asserts `cap_we`.
- R8: While `cfg_done` is 0, no readback runs and any transfer in progress ends, so `sdo` is 1. `gts` equals `!cfg_done && !req_n`.
- R9: After reset, `sdo` is 1, `cap_we` is 0 unless level capture is active, and the edge history is cleared, so a request needs two high edges first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Configuration complete; readback is enabled only when 1 |
| req_n | input | 1 | Active-low readback request |
| perm | input | 2 | Readback permission (00 none, 01 once, 1x unlimited) |
| cap_mode | input | 2 | Capture mode (bit 0 on entry, bit 1 level-controlled) |
| cap_ctl_n | input | 1 | Internal capture control, captures while 0 |
| rd_bit | input | 1 | Bit returned from the configuration/capture store |
| rd_addr | output | $clog2(FRAMES*FRAME_BITS) | Bit address into the store |
| sdo | output | 1 | Serial readback data |
| cap_we | output | 1 | Capture memory write strobe |
| gts | output | 1 | Global 3-state drive while configuration is incomplete |

## Verification
In capture mode 3, the entry pulse and the level-controlled capture can fall in the same cycle. The bench provokes this by pulling `cap_ctl_n` low in the very cycle the request is accepted and then toggling it during the latency window. A behavioural model ORs the two sources separately, and `cap_we` is compared against it every cycle. A release of the request can also coincide with the end of a frame. The bench releases at several points, both mid-frame and after the last stop bit, and checks that the output drops to idle-high and that a restart begins again at frame 0.

// File: rtl/cfg_readback_ser.sv
module cfg_readback_ser #(
  parameter int FRAME_BITS = 8,
  parameter int FRAMES     = 4,
  parameter int LATENCY    = 4,
  localparam int AW = (FRAMES * FRAME_BITS > 1) ? $clog2(FRAMES * FRAME_BITS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_done,
  input  logic          req_n,
  input  logic [1:0]    perm,
  input  logic [1:0]    cap_mode,
  input  logic          cap_ctl_n,
  input  logic          rd_bit,
  output logic [AW-1:0] rd_addr,
  output logic          sdo,
  output logic          cap_we,
  output logic          gts
);

  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam int FW = (FRAMES > 1) ? $clog2(FRAMES) : 1;
  localparam int LW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_DATA, S_STOP, S_DONE} st_t;

  st_t           state;
  logic [1:0]    hi;
  logic          used;
  logic [LW-1:0] wcnt;
  logic [BW-1:0] bcnt;
  logic [FW-1:0] fcnt;
  logic          allow, start_ok;

  assign allow    = perm[1] | (perm == 2'b01 && !used);
  assign start_ok = cfg_done & ~req_n & (hi == 2'd2) & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      hi    <= 2'd0;
      used  <= 1'b0;
      wcnt  <= '0;
      bcnt  <= '0;
      fcnt  <= '0;
    end else begin
      hi <= req_n ? ((hi == 2'd2) ? 2'd2 : hi + 2'd1) : 2'd0;
      if (!cfg_done || (state != S_IDLE && req_n)) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (start_ok) begin
            state <= S_WAIT;
            wcnt  <= '0;
            fcnt  <= '0;
            used  <= 1'b1;
          end
          S_WAIT: if (wcnt == LW'(LATENCY - 1)) state <= S_START;
                  else wcnt <= wcnt + 1'b1;
          S_START: begin
            state <= S_DATA;
            bcnt  <= '0;
          end
          S_DATA: if (bcnt == BW'(FRAME_BITS - 1)) state <= S_STOP;
                  else bcnt <= bcnt + 1'b1;
          S_STOP: if (fcnt == FW'(FRAMES - 1)) state <= S_DONE;
                  else begin
                    fcnt  <= fcnt + 1'b1;
                    state <= S_START;
                  end
          default: state <= state;
        endcase
      end
    end
  end

  assign rd_addr = AW'(fcnt) * AW'(FRAME_BITS) + AW'(bcnt);
  assign sdo     = (state == S_START) ? 1'b0 : (state == S_DATA) ? rd_bit : 1'b1;
  assign cap_we  = (cap_mode[0] & (state == S_WAIT) & (wcnt == '0))
                 | (cap_mode[1] & ~cap_ctl_n & cfg_done);
  assign gts     = ~cfg_done & ~req_n;

  p_latency_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && wcnt == LW'(LATENCY - 1) && !req_n && cfg_done) |=> !sdo);

  p_stop_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA && bcnt == BW'(FRAME_BITS - 1) && !req_n && cfg_done)
      |=> (state == S_STOP && sdo));

  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && req_n) |=> (state == S_IDLE && sdo));

  p_prohibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (perm == 2'b00 && state == S_IDLE) |=> state == S_IDLE);

  p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (perm == 2'b01 && used && state == S_IDLE) |=> state == S_IDLE);

  p_used_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    used |=> used);

  p_entry_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_ok && cap_mode[0]) |=> (cap_we || !cap_mode[0]));

  p_cfg_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |=> state == S_IDLE);

endmodule

// File: tb/cfg_readback_ser_test.sv
module cfg_readback_ser_test;
  localparam int CLK_P = 10;
  localparam int FB = 8;
  localparam int NF = 4;
  localparam int LAT = 4;
  localparam int AW = $clog2(NF * FB);
  localparam int FULL = LAT + NF * (FB + 2) + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0, cfg_done = 1'b0, req_n = 1'b1, cap_ctl_n = 1'b1;
  logic [1:0] perm = 2'b10, cap_mode = 2'b00;
  logic rd_bit, sdo, cap_we, gts;
  logic [AW-1:0] rd_addr;
  logic mem [0:NF*FB-1];

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  string tag = "R9";

  int m_hi = 0;
  bit m_used = 0, m_act = 0, m_entry = 0;
  bit q[$];

  always #(CLK_P/2) clk = ~clk;

  assign rd_bit = mem[rd_addr];

  cfg_readback_ser #(.FRAME_BITS(FB), .FRAMES(NF), .LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .req_n(req_n), .perm(perm),
    .cap_mode(cap_mode), .cap_ctl_n(cap_ctl_n), .rd_bit(rd_bit), .rd_addr(rd_addr),
    .sdo(sdo), .cap_we(cap_we), .gts(gts));

  initial for (int i = 0; i < NF*FB; i++) mem[i] = (((i * 5 + 3) % 7) < 3);

  // reference model: R1..R6, R8, R9 sequencing
  always @(posedge clk) begin
    bit ok;
    if (!rst_n) begin
      m_hi = 0; m_used = 0; m_act = 0; m_entry = 0; q.delete();
    end else begin
      ok = perm[1] || (perm == 2'b01 && !m_used);
      m_entry = 0;
      if (!cfg_done || (m_act && req_n)) begin
        m_act = 0; q.delete();
      end else if (!m_act && !req_n && m_hi >= 2 && ok) begin
        m_act = 1; m_used = 1; m_entry = 1; q.delete();
        for (int k = 0; k < LAT; k++) q.push_back(1'b1);
        for (int f = 0; f < NF; f++) begin
          q.push_back(1'b0);
          for (int b = 0; b < FB; b++) q.push_back(mem[f*FB + b]);
          q.push_back(1'b1);
        end
      end else if (m_act && q.size() > 0) begin
        void'(q.pop_front());
      end
      m_hi = req_n ? ((m_hi >= 2) ? 2 : m_hi + 1) : 0;
    end
  end

  always @(negedge clk) begin
    bit e_sdo, e_cap, e_gts;
    if (!finished) begin
      e_sdo = (m_act && q.size() > 0) ? q[0] : 1'b1;
      e_cap = (cap_mode[0] && m_entry) || (cap_mode[1] && !cap_ctl_n && cfg_done);
      e_gts = !cfg_done && !req_n;
      checks += 3;
      if (sdo !== e_sdo) begin
        errors++;
        $display("FAIL %s sdo got %0b exp %0b at %0t", tag, sdo, e_sdo, $time);
      end
      if (cap_we !== e_cap) begin
        errors++;
        $display("FAIL %s cap_we got %0b exp %0b at %0t", tag, cap_we, e_cap, $time);
      end
      if (gts !== e_gts) begin
        errors++;
        $display("FAIL %s gts got %0b exp %0b at %0t", tag, gts, e_gts, $time);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;                       // R9 reset state
    tag = "R8";
    cyc(3); req_n = 1'b0;               // gts follows request before configuration
    cyc(2); req_n = 1'b1;
    cyc(3); req_n = 1'b0;               // no readback while unconfigured
    cyc(4); req_n = 1'b1; cfg_done = 1'b1; cap_mode = 2'b01;
    tag = "R1/R2/R3/R7";
    cyc(3); req_n = 1'b0;               // full transfer, entry capture
    cyc(FULL);
    tag = "R4";
    req_n = 1'b1; cyc(1); req_n = 1'b0; // single high edge: no restart
    cyc(6); req_n = 1'b1;
    cyc(2); req_n = 1'b0;               // proper restart
    cyc(LAT + FB + 5); req_n = 1'b1;    // abort mid-frame
    cyc(3); req_n = 1'b0;               // restart from frame 0
    cyc(FULL); req_n = 1'b1;
    tag = "R7";
    cyc(3); cap_mode = 2'b11; cap_ctl_n = 1'b0; req_n = 1'b0; // both capture sources at once
    cyc(3); cap_ctl_n = 1'b1;
    cyc(2); cap_ctl_n = 1'b0;
    cyc(2); cap_mode = 2'b10; cap_ctl_n = 1'b1;
    cyc(2); cap_ctl_n = 1'b0;
    cyc(2); cap_mode = 2'b00;
    cyc(2); cap_ctl_n = 1'b1; req_n = 1'b1;
    tag = "R5";
    cyc(3); perm = 2'b00; req_n = 1'b0; // prohibited
    cyc(LAT + 6); req_n = 1'b1;
    tag = "R6";
    cyc(2); rst_n = 1'b0;
    cyc(2); rst_n = 1'b1; perm = 2'b01; cap_mode = 2'b01;
    cyc(3); req_n = 1'b0;               // first and only readback
    cyc(FULL); req_n = 1'b1;
    cyc(3); req_n = 1'b0;               // second request ignored
    cyc(LAT + 8); req_n = 1'b1;
    tag = "R8";
    cyc(3); perm = 2'b11; req_n = 1'b0; // configuration drops mid-transfer
    cyc(LAT + 3); cfg_done = 1'b0;
    cyc(4); req_n = 1'b1;
    cyc(3);
    finish_run();
  end
endmodule